// File: doc/BRIEF.md
# Register-File Serial Slave with Strapped Address and Pointer Autoincrement

This block is the two-wire serial slave in front of a small register file. It samples the clock and data lines of an I2C bus, finds START and STOP conditions, and answers a 7-bit address. The upper three bits of that address are fixed at binary 010. The lower four come from strap pins, which are sampled once as reset is released. The block also accepts a broadcast write address that every device on the bus shares, so one transaction can load the same register in all of them.

A write carries a command byte after the address byte. The command byte loads an internal register pointer. Each data byte after it goes to the register at the pointer, and the pointer then advances by one. A STOP directly after the command byte therefore only moves the pointer. A read returns the register at the pointer and advances it. The master either acknowledges to continue or sends a NACK to end the read.

The block drives the data line only through an open-drain enable. Clock stretching and 10-bit addressing are not supported.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave address is 7 bits sent MSB first: binary 010 followed by the latched straps, bit 3 first. The eighth bit is R/W (0 = write, 1 = read). On a match the slave acknowledges by asserting `sdaOe` (SDA pulled low) for the ninth clock. It changes `sdaOe` only while SCL is low.
- R2: The straps are captured once, on the first clock after reset is released. Later changes on the strap pins do not change the address. Register index 0x11 reads back the captured straps in bits 3:0, with bits 7:4 zero. Writes to index 0x11 are discarded, but the pointer still advances.
- R3: An address that does not match is not acknowledged. The slave then leaves SDA released and writes nothing until the next START.
- R4: Address byte 0x60 (7-bit 0x30, write) is accepted as a broadcast write and acknowledged. Byte 0x61 (a read to that address) is not acknowledged.
- R5: In a write, the first byte after the address loads the register pointer and is acknowledged. A STOP right after it leaves every register unchanged.
- R6: Each later data byte in a write is acknowledged, stored at the pointer, and the pointer then advances by one.
- R7: In a read, each byte is sent MSB first from the register at the pointer, and the pointer then advances by one. A master ACK (0) fetches the next byte. A master NACK (1) ends the read with SDA released.
- R8: A repeated START, without a STOP, returns the slave to address reception. The pointer is kept.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After reset and after a STOP, `sdaOe` is low. All writable registers reset to zero.
- R10: Pointer values at or above NUM_REGS select no register: writes there are discarded and reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapPins | input | 4 | Address straps, captured as reset is released |
| sclIn | input | 1 | Bus clock line as sampled |
| sdaIn | input | 1 | Bus data line as sampled |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
Some rules are checked on every cycle. `sdaOe` only changes while the synchronized clock is low. It stays low while the slave ignores the bus and after a STOP. Every stored data byte and every fetched read byte advances the pointer by exactly one. The latched strap value never moves after capture.

Other behaviour needs the bench's scripted transfers, because the result is only visible as acknowledge bits and read-back bytes across several transactions. This covers the address match with re-strapped pins, the broadcast write, and discarded writes to the strap register and to out-of-range indices. It also covers pointer-only commands ended by STOP and the continuation across repeated START.

// File: rtl/i2cSlvPkg.sv
package i2cSlvPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } slvState_e;

  // Strobes from control to datapath, valid for a single clock
  typedef struct packed {
    logic shiftRx;   // shift sampled bit into receive byte
    logic rxBit;     // the sampled data bit
    logic loadPtr;   // command byte complete: load pointer
    logic writeReg;  // data byte complete: store and advance
    logic loadTx;    // fetch register at pointer, advance
    logic shiftTx;   // move to next transmit bit
  } slvStrobe_t;

endpackage

// File: rtl/i2cSlvSync.sv
module i2cSlvSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '1;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2cSlvCtrl.sv
module i2cSlvCtrl
  import i2cSlvPkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          STRAP_W     = 4,
  parameter logic [7:0]  BCAST_BYTE  = 8'h60
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic [STRAP_W-1:0] strapVal,
  input  logic               txMsb,
  output slvStrobe_t         strb,
  output logic               sdaOe,
  output logic               sclLvl,
  output logic               ignoring,
  output logic               stopDet
);

  localparam int         HI_W    = 7 - STRAP_W;
  localparam logic [2:0] FIXED_HI = 3'b010;

  logic [1:0] busSync;
  logic       sclNow, sdaNow, sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet;
  logic [6:0] ownAddr;
  logic       ownHit, bcastHit;

  i2cSlvSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclIn, sdaIn}),
    .dout (busSync)
  );

  assign sclNow = busSync[1];
  assign sdaNow = busSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign sclLvl   = sclNow;

  assign ownAddr  = {FIXED_HI[HI_W-1:0], strapVal};
  assign ownHit   = (rxByte[7:1] == ownAddr);
  assign bcastHit = (rxByte == BCAST_BYTE);

  slvState_e state, stateN, afterAck, afterAckN;
  logic [2:0] bitCnt, bitCntN;
  logic       gotByte, gotByteN;
  logic       ackDrive, ackDriveN;
  logic       readDrive, readDriveN;
  logic       masterNack, masterNackN;

  always_comb begin
    stateN      = state;
    afterAckN   = afterAck;
    bitCntN     = bitCnt;
    gotByteN    = gotByte;
    ackDriveN   = ackDrive;
    readDriveN  = readDrive;
    masterNackN = masterNack;
    strb        = '0;
    strb.rxBit  = sdaNow;

    if (startDet) begin
      stateN     = ST_ADDR;
      bitCntN    = '0;
      gotByteN   = 1'b0;
      ackDriveN  = 1'b0;
      readDriveN = 1'b0;
    end else if (stopDet) begin
      stateN     = ST_IDLE;
      bitCntN    = '0;
      gotByteN   = 1'b0;
      ackDriveN  = 1'b0;
      readDriveN = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (sclRise && !gotByte) begin
            strb.shiftRx = 1'b1;
            bitCntN      = bitCnt + 3'd1;
            if (bitCnt == 3'd7) gotByteN = 1'b1;
          end else if (sclFall && gotByte) begin
            gotByteN = 1'b0;
            bitCntN  = '0;
            if (state == ST_ADDR) begin
              if (ownHit) begin
                ackDriveN = 1'b1;
                stateN    = ST_ACK;
                afterAckN = rxByte[0] ? ST_RDATA : ST_CMD;
              end else if (bcastHit) begin
                ackDriveN = 1'b1;
                stateN    = ST_ACK;
                afterAckN = ST_CMD;
              end else begin
                stateN = ST_IGNORE;
              end
            end else if (state == ST_CMD) begin
              strb.loadPtr = 1'b1;
              ackDriveN    = 1'b1;
              stateN       = ST_ACK;
              afterAckN    = ST_WDATA;
            end else begin
              strb.writeReg = 1'b1;
              ackDriveN     = 1'b1;
              stateN        = ST_ACK;
              afterAckN     = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackDriveN = 1'b0;
            stateN    = afterAck;
            bitCntN   = '0;
            if (afterAck == ST_RDATA) begin
              strb.loadTx = 1'b1;
              readDriveN  = 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            bitCntN = bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              readDriveN = 1'b0;
              stateN     = ST_RACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            masterNackN = sdaNow;
          end else if (sclFall) begin
            bitCntN = '0;
            if (masterNack) begin
              stateN = ST_IGNORE;
            end else begin
              strb.loadTx = 1'b1;
              readDriveN  = 1'b1;
              stateN      = ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      afterAck   <= ST_CMD;
      bitCnt     <= '0;
      gotByte    <= 1'b0;
      ackDrive   <= 1'b0;
      readDrive  <= 1'b0;
      masterNack <= 1'b1;
    end else begin
      state      <= stateN;
      afterAck   <= afterAckN;
      bitCnt     <= bitCntN;
      gotByte    <= gotByteN;
      ackDrive   <= ackDriveN;
      readDrive  <= readDriveN;
      masterNack <= masterNackN;
    end
  end

  assign sdaOe    = ackDrive | (readDrive & ~txMsb);
  assign ignoring = (state == ST_IGNORE);

endmodule

// File: rtl/i2cSlvDatapath.sv
module i2cSlvDatapath
  import i2cSlvPkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int STRAP_W   = 4,
  parameter int STRAP_IDX = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapPins,
  input  slvStrobe_t         strb,
  output logic [BYTE_W-1:0]  rxByte,
  output logic [BYTE_W-1:0]  ptr,
  output logic [STRAP_W-1:0] strapLatch,
  output logic               capDone,
  output logic               txMsb
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [BYTE_W-1:0] txReg;
  logic [BYTE_W-1:0] rdData;
  logic [BYTE_W-1:0] regQ [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDone    <= 1'b0;
      strapLatch <= '0;
    end else if (!capDone) begin
      capDone    <= 1'b1;
      strapLatch <= strapPins;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxByte <= '0;
    else if (strb.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], strb.rxBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            ptr <= '0;
    else if (strb.loadPtr)                ptr <= rxByte;
    else if (strb.writeReg || strb.loadTx) ptr <= ptr + 8'd1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    if (i == STRAP_IDX) begin : gStrap
      assign regQ[i] = {{(BYTE_W-STRAP_W){1'b0}}, strapLatch};
    end else begin : gData
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  q <= '0;
        else if (strb.writeReg && ptr == BYTE_W'(i)) q <= rxByte;
      end
      assign regQ[i] = q;
    end
  end

  assign rdData = (int'(ptr) < NUM_REGS) ? regQ[ptr[IDX_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txReg <= '0;
    else if (strb.loadTx)  txReg <= rdData;
    else if (strb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b0};
  end

  assign txMsb = txReg[BYTE_W-1];

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cSlvPkg::*;
#(
  parameter int         NUM_REGS    = 32,
  parameter int         STRAP_IDX   = 17,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] BCAST_BYTE  = 8'h60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] strapPins,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe
);

  localparam int STRAP_W = 4;

  slvStrobe_t         ctrlStrb;
  logic [BYTE_W-1:0]  rxByte;
  logic [BYTE_W-1:0]  curPtr;
  logic [STRAP_W-1:0] strapLatch;
  logic               capDone;
  logic               txMsb;
  logic               sclLvl;
  logic               ignoring;
  logic               stopDet;

  i2cSlvCtrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .STRAP_W     (STRAP_W),
    .BCAST_BYTE  (BCAST_BYTE)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rxByte   (rxByte),
    .strapVal (strapLatch),
    .txMsb    (txMsb),
    .strb     (ctrlStrb),
    .sdaOe    (sdaOe),
    .sclLvl   (sclLvl),
    .ignoring (ignoring),
    .stopDet  (stopDet)
  );

  i2cSlvDatapath #(
    .NUM_REGS  (NUM_REGS),
    .STRAP_W   (STRAP_W),
    .STRAP_IDX (STRAP_IDX)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strapPins  (strapPins),
    .strb       (ctrlStrb),
    .rxByte     (rxByte),
    .ptr        (curPtr),
    .strapLatch (strapLatch),
    .capDone    (capDone),
    .txMsb      (txMsb)
  );

endmodule

// File: rtl/i2cSlvChk.sv
module i2cSlvChk (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclLvl,
  input logic       ignoring,
  input logic       stopDet,
  input logic       wrStb,
  input logic       ldTxStb,
  input logic [7:0] ptr,
  input logic       capDone,
  input logic [3:0] strapLatch
);

  // R1
  sda_move_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaOe) |-> !$past(sclLvl));

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ignoring |-> !sdaOe);

  // R6
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> ptr == $past(ptr) + 8'd1);

  // R7
  rd_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldTxStb |=> ptr == $past(ptr) + 8'd1);

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capDone && $past(capDone)) |-> $stable(strapLatch));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

endmodule

bind i2c_reg_slave i2cSlvChk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .sdaOe      (sdaOe),
  .sclLvl     (sclLvl),
  .ignoring   (ignoring),
  .stopDet    (stopDet),
  .wrStb      (ctrlStrb.writeReg),
  .ldTxStb    (ctrlStrb.loadTx),
  .ptr        (curPtr),
  .capDone    (capDone),
  .strapLatch (strapLatch)
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;

  localparam int Q = 10;  // clocks per quarter bit

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] strapPins;
  logic       mScl, mSda;
  logic       sdaBus;
  logic       sdaOe;

  always #2.5 clk = ~clk;

  assign sdaBus = mSda & ~sdaOe;

  i2c_reg_slave u0 (
    .clk       (clk),
    .rstN      (rstN),
    .strapPins (strapPins),
    .sclIn     (mScl),
    .sdaIn     (sdaBus),
    .sdaOe     (sdaOe)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } sbItem_t;

  sbItem_t    expQ[$];
  logic [7:0] obsQ[$];
  int nChecks = 0;
  int nErr    = 0;
  bit done    = 1'b0;

  task automatic doCheck(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        sbItem_t e;
        logic [7:0] o;
        o = obsQ.pop_front();
        if (expQ.size() == 0) begin
          nChecks++; nErr++;
          $display("FAIL scoreboard: actual %h expected none", o);
        end else begin
          e = expQ.pop_front();
          doCheck(o, e.val, e.tag);
        end
      end
    end
  end

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart;
    mScl = 1'b0; waitQ;
    mSda = 1'b1; waitQ;
    mScl = 1'b1; waitQ;
    mSda = 1'b0; waitQ;
    mScl = 1'b0; waitQ;
  endtask

  task automatic busStop;
    mScl = 1'b0; mSda = 1'b0; waitQ;
    mScl = 1'b1; waitQ;
    mSda = 1'b1; waitQ;
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitQ;
    mScl = 1'b1; waitQ; waitQ;
    mScl = 1'b0; waitQ;
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; waitQ;
    mScl = 1'b1; waitQ;
    b = sdaBus; waitQ;
    mScl = 1'b0; waitQ;
  endtask

  // write a byte; expNack=0 means acknowledge expected
  task automatic wrB(input logic [7:0] b, input logic expNack, input string tag);
    logic a;
    expQ.push_back('{val: {7'd0, expNack}, tag: tag});
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    getBit(a);
    obsQ.push_back({7'd0, a});
  endtask

  // read a byte; last=1 sends NACK
  task automatic rdB(input logic [7:0] expV, input logic last, input string tag);
    logic [7:0] v;
    logic b;
    v = '0;
    expQ.push_back('{val: expV, tag: tag});
    for (int i = 0; i < 8; i++) begin
      getBit(b);
      v = {v[6:0], b};
    end
    obsQ.push_back(v);
    sendBit(last);
  endtask

  // own address with straps 0101: write 0x4A, read 0x4B
  localparam logic [7:0] OWN_W = 8'h4A;
  localparam logic [7:0] OWN_R = 8'h4B;

  initial begin
    rstN = 1'b0; mScl = 1'b1; mSda = 1'b1; strapPins = 4'b0101;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    doCheck({7'd0, sdaOe}, 8'h00, "R9 reset sdaOe");
    strapPins = 4'b1010;  // must not move the address (R2)

    // R1 R6: multi-byte write
    busStart;
    wrB(OWN_W, 1'b0, "R1 own addr ack");
    wrB(8'h03, 1'b0, "R5 cmd ack");
    wrB(8'hA1, 1'b0, "R6 data0 ack");
    wrB(8'hB2, 1'b0, "R6 data1 ack");
    wrB(8'hC3, 1'b0, "R6 data2 ack");
    busStop;
    repeat (5) @(negedge clk);
    doCheck({7'd0, sdaOe}, 8'h00, "R9 released after stop");

    // R8 R7: repeated start read
    busStart;
    wrB(OWN_W, 1'b0, "R8 addr");
    wrB(8'h03, 1'b0, "R8 cmd");
    busStart;
    wrB(OWN_R, 1'b0, "R8 read addr after rstart");
    rdB(8'hA1, 1'b0, "R7 read reg3");
    rdB(8'hB2, 1'b0, "R7 read reg4");
    rdB(8'hC3, 1'b1, "R7 read reg5 nack");
    busStop;

    // R2: strap register and re-strapped address
    busStart;
    wrB(OWN_W, 1'b0, "R2 addr");
    wrB(8'h11, 1'b0, "R2 cmd");
    busStart;
    wrB(OWN_R, 1'b0, "R2 read addr");
    rdB(8'h05, 1'b1, "R2 strap readback");
    busStop;
    busStart;
    wrB(8'h54, 1'b1, "R2 new strap addr nack");
    busStop;

    // R2: write to strap register discarded
    busStart;
    wrB(OWN_W, 1'b0, "R2 addr");
    wrB(8'h11, 1'b0, "R2 cmd");
    wrB(8'h77, 1'b0, "R2 write ro ack");
    busStop;

    // R9: register reset value
    busStart;
    wrB(OWN_W, 1'b0, "R9 addr");
    wrB(8'h00, 1'b0, "R9 cmd");
    busStart;
    wrB(OWN_R, 1'b0, "R9 read addr");
    rdB(8'h00, 1'b1, "R9 reg0 reset zero");
    busStop;

    // R3: foreign address ignored
    busStart;
    wrB(8'h52, 1'b1, "R3 foreign addr nack");
    wrB(8'h03, 1'b1, "R3 ignored cmd");
    wrB(8'hFF, 1'b1, "R3 ignored data");
    busStop;
    busStart;
    wrB(OWN_W, 1'b0, "R3 addr");
    wrB(8'h03, 1'b0, "R3 cmd");
    busStart;
    wrB(OWN_R, 1'b0, "R3 read addr");
    rdB(8'hA1, 1'b1, "R3 reg3 untouched");
    busStop;

    // R4: broadcast
    busStart;
    wrB(8'h60, 1'b0, "R4 bcast ack");
    wrB(8'h07, 1'b0, "R4 bcast cmd");
    wrB(8'h5A, 1'b0, "R4 bcast data");
    busStop;
    busStart;
    wrB(8'h61, 1'b1, "R4 bcast read nack");
    busStop;
    busStart;
    wrB(OWN_W, 1'b0, "R4 addr");
    wrB(8'h07, 1'b0, "R4 cmd");
    busStart;
    wrB(OWN_R, 1'b0, "R4 read addr");
    rdB(8'h5A, 1'b1, "R4 reg7 bcast value");
    busStop;

    // R5: pointer only
    busStart;
    wrB(OWN_W, 1'b0, "R5 addr");
    wrB(8'h04, 1'b0, "R5 cmd only");
    busStop;
    busStart;
    wrB(OWN_R, 1'b0, "R5 read addr");
    rdB(8'hB2, 1'b0, "R5 reg4 unchanged");
    rdB(8'hC3, 1'b1, "R5 reg5 next");
    busStop;

    // R2: strap register still holds straps after write
    busStart;
    wrB(OWN_W, 1'b0, "R2 addr");
    wrB(8'h11, 1'b0, "R2 cmd");
    busStart;
    wrB(OWN_R, 1'b0, "R2 read addr");
    rdB(8'h05, 1'b1, "R2 strap after write");
    busStop;

    // R10: out of range
    busStart;
    wrB(OWN_W, 1'b0, "R10 addr");
    wrB(8'h1F, 1'b0, "R10 cmd");
    wrB(8'h11, 1'b0, "R10 last reg data");
    wrB(8'h22, 1'b0, "R10 out of range data");
    busStop;
    busStart;
    wrB(OWN_W, 1'b0, "R10 addr");
    wrB(8'h1F, 1'b0, "R10 cmd");
    busStart;
    wrB(OWN_R, 1'b0, "R10 read addr");
    rdB(8'h11, 1'b0, "R10 reg31");
    rdB(8'h00, 1'b1, "R10 beyond range zero");
    busStop;

    repeat (20) @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nErr++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule